// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Register Controller

This block is a word-wide register front end for a 1024-byte one-time-programmable fuse store. Software sets a byte address and a bit position in an address register. It then writes command words to a write-only command register. A read command copies the addressed fuse byte into a data register. A guarded two-word program command sets exactly one fuse bit. A fuse bit never goes from one back to zero.

A configuration register holds sticky bits that software can only set. Each lock bit in one byte of that register freezes the matching bit in the two bytes below it. A status register reports ready and operation-done, and it holds an interrupt enable bit. The fuse store is a bank of registers. A parameter selects whether reset also wipes the store.

Accesses are whole 32-bit words. They travel over a synchronous port: one request per cycle, a 4-bit word index, and an acknowledge with read data one cycle after the request.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the status word (index 0) reads 0x00000001, the configuration word (index 3) reads 0x20000000, and the address (index 1) and data (index 2) words read zero.
- R2: `ack` is high in exactly the cycle after each cycle in which `req` is high. `rdata` in that cycle carries the addressed register's value from before the access for a read, and zero for a write.
- R3: The address word keeps written bits [12:0]: a byte address in [9:0] and a bit position in [12:10]. Bits [31:13] read zero.
- R4: Writing 0x00000002 to the command word (index 5) loads the addressed fuse byte, zero-extended, into the data word and sets status bits 0 (ready) and 1 (done).
- R5: Writing 0xBF79E5D0 to the command word, when the previous command-word write was 0x00000001, sets the fuse bit named by the address word and sets status bits 0 and 1. Writes to other registers in between do not break the pairing.
- R6: The 0xBF79E5D0 word does nothing in two cases: when no 0x00000001 came first, or when another command word came in between.
- R7: Programming only ever sets a fuse bit. Programming a bit that is already set leaves the byte unchanged, and separate programs of different bits accumulate.
- R8: Writing exactly 0x00000001 to the data word clears it. Any other written value leaves it unchanged.
- R9: Status bits 0 and 1 cannot be set by software. Writing 1 to bit 1 clears it. Bit 2 stores the written value. Bits [31:3] read zero.
- R10: Configuration bit 31 and bits [23:16] are set by writing 1 and cannot be cleared by a write. The remaining bits take the written value unless locked.
- R11: While configuration bit 16+k is set, bits k and 8+k of the configuration word keep their value across writes (k = 0..7).
- R12: Reads of the command word, the reserved index 4 and indices 6..15 return zero. Writes to indices 4 and 6..15 change no register.
- R13: With the clear-on-reset option (the default), reset returns every fuse bit to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| idx | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access acknowledge, one cycle after the request |
| rdata | output | 32 | Read data, valid with `ack` |

## Verification
The program path is driven with four patterns. The first is a correct arm-then-fire pair. The second is a fire word with no arm. The third is an arm broken by a read command. The fourth is an arm followed by an address-register write and then the fire word. Reading the byte back after each pattern separates pairing that is tracked per command write from pairing that is tracked per bus access. A second program of a bit that is already set, and a read of an untouched neighbouring byte, show whether programming is a pure OR into the addressed byte or disturbs other bits. Configuration writes alternate between locked and unlocked lanes, which exposes whether sticky bits and lock masks come from the current value or from the written value.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

  localparam int REG_W = 32;

  // word indices on the register port
  localparam logic [3:0] IX_STAT = 4'd0;
  localparam logic [3:0] IX_ADDR = 4'd1;
  localparam logic [3:0] IX_DATA = 4'd2;
  localparam logic [3:0] IX_CFG  = 4'd3;
  localparam logic [3:0] IX_CMD  = 4'd5;

  // command and data words
  localparam logic [REG_W-1:0] CMD_LOAD = 32'h0000_0002;
  localparam logic [REG_W-1:0] CMD_ARM  = 32'h0000_0001;
  localparam logic [REG_W-1:0] CMD_FIRE = 32'hBF79_E5D0;
  localparam logic [REG_W-1:0] DATA_WIPE = 32'h0000_0001;

  // status bit positions
  localparam int ST_RDY  = 0;
  localparam int ST_DONE = 1;
  localparam int ST_IE   = 2;

  // configuration layout
  localparam logic [REG_W-1:0] CFG_INIT   = 32'h2000_0000;
  localparam logic [REG_W-1:0] CFG_STICKY = 32'h80FF_0000;

endpackage

// File: rtl/fuse_bitstore.sv
module fuse_bitstore #(
  parameter int DEPTH          = 1024,
  parameter bit CLEAR_ON_RESET = 1'b1,
  localparam int AW            = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [2:0]    set_bit,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);

  logic [7:0] mem [DEPTH];

  generate
    if (CLEAR_ON_RESET) begin : g_wipe
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (set_en) begin
          mem[set_addr][set_bit] <= 1'b1;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (set_en) mem[set_addr][set_bit] <= 1'b1;
      end
    end
  endgenerate

  assign rd_byte = mem[rd_addr];

  // guard flag: high only once a full cycle has passed since reset
  logic live_q;
  always_ff @(posedge clk) live_q <= !rst;

  p_set_lands_r5: assert property (@(posedge clk) disable iff (rst)
    set_en |=> mem[$past(set_addr)][$past(set_bit)]);

  p_monotone_r7: assert property (@(posedge clk) disable iff (rst)
    live_q |=> ((mem[$past(rd_addr)] & $past(rd_byte)) == $past(rd_byte)));

endmodule

// File: rtl/fuse_cfg_lock.sv
module fuse_cfg_lock
  import fuse_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_q
);

  logic [7:0]       lk;
  logic [REG_W-1:0] frozen;
  logic [REG_W-1:0] cfg_nxt;

  always_comb begin
    lk      = cfg_q[23:16];
    frozen  = {16'h0000, lk, lk};
    cfg_nxt = (cfg_q & CFG_STICKY) | (cfg_q & frozen) | (wr_data & ~frozen);
  end

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= CFG_INIT;
    else if (wr_en) cfg_q <= cfg_nxt;
  end

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cfg_q & $past(cfg_q) & CFG_STICKY) == ($past(cfg_q) & CFG_STICKY)));

  p_lock_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((cfg_q[7:0] ^ $past(cfg_q[7:0])) |
                (cfg_q[15:8] ^ $past(cfg_q[15:8]))) & $past(cfg_q[23:16])) == 8'h00));

endmodule

// File: rtl/fuse_cmd_seq.sv
module fuse_cmd_seq
  import fuse_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             load_go,
  output logic             prog_go
);

  logic armed_q;

  assign load_go = wr_en && (wr_data == CMD_LOAD);
  assign prog_go = wr_en && (wr_data == CMD_FIRE) && armed_q;

  // only command-word writes move the arm flag
  always_ff @(posedge clk) begin
    if (rst)        armed_q <= 1'b0;
    else if (wr_en) armed_q <= (wr_data == CMD_ARM);
  end

  p_arm_broken_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data != CMD_ARM)) |=> !prog_go);

  p_one_op_r4: assert property (@(posedge clk) disable iff (rst)
    !(load_go && prog_go));

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_ctl_pkg::*;
#(
  parameter int DEPTH          = 1024,
  parameter bit CLEAR_ON_RESET = 1'b1,
  localparam int AW            = $clog2(DEPTH),
  localparam int ADDR_BITS     = AW + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [3:0]       idx,
  input  logic [REG_W-1:0] wdata,
  output logic             ack,
  output logic [REG_W-1:0] rdata
);

  logic wr_stat, wr_addr, wr_data, wr_cfg, wr_cmd;
  logic load_go, prog_go;

  logic                 rdy_q, done_q, ie_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [7:0]           data_q;
  logic [REG_W-1:0]     cfg_q;
  logic [7:0]           fuse_byte;
  logic [REG_W-1:0]     rd_mux;

  always_comb begin
    wr_stat = req && we && (idx == IX_STAT);
    wr_addr = req && we && (idx == IX_ADDR);
    wr_data = req && we && (idx == IX_DATA);
    wr_cfg  = req && we && (idx == IX_CFG);
    wr_cmd  = req && we && (idx == IX_CMD);
  end

  fuse_cmd_seq u_cmd (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_cmd),
    .wr_data (wdata),
    .load_go (load_go),
    .prog_go (prog_go)
  );

  fuse_cfg_lock u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_cfg),
    .wr_data (wdata),
    .cfg_q   (cfg_q)
  );

  fuse_bitstore #(
    .DEPTH          (DEPTH),
    .CLEAR_ON_RESET (CLEAR_ON_RESET)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .set_en   (prog_go),
    .set_addr (addr_q[AW-1:0]),
    .set_bit  (addr_q[AW+2:AW]),
    .rd_addr  (addr_q[AW-1:0]),
    .rd_byte  (fuse_byte)
  );

  // status word
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b1;
      done_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (load_go || prog_go) begin
      rdy_q  <= 1'b1;
      done_q <= 1'b1;
    end else if (wr_stat) begin
      ie_q <= wdata[ST_IE];
      if (wdata[ST_DONE]) done_q <= 1'b0;
    end
  end

  // address word
  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (wr_addr) addr_q <= wdata[ADDR_BITS-1:0];
  end

  // data word
  always_ff @(posedge clk) begin
    if (rst)                               data_q <= '0;
    else if (load_go)                      data_q <= fuse_byte;
    else if (wr_data && wdata == DATA_WIPE) data_q <= '0;
  end

  always_comb begin
    case (idx)
      IX_STAT: rd_mux = {29'd0, ie_q, done_q, rdy_q};
      IX_ADDR: rd_mux = {{(REG_W-ADDR_BITS){1'b0}}, addr_q};
      IX_DATA: rd_mux = {24'd0, data_q};
      IX_CFG:  rd_mux = cfg_q;
      default: rd_mux = '0;
    endcase
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      rdata <= (req && !we) ? rd_mux : '0;
    end
  end

  p_ack_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);

  p_ack_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ack);

  p_prog_done_r5: assert property (@(posedge clk) disable iff (rst)
    prog_go |=> (done_q && rdy_q));

  p_done_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[ST_DONE]) |=> !done_q);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_data && (wdata != DATA_WIPE)) |=> $stable(data_q));

endmodule

// File: tb/fuse_ctl_test.sv
module fuse_ctl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we  = 1'b0;
  logic [3:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fuse_ctl uut (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .we    (we),
    .idx   (idx),
    .wdata (wdata),
    .ack   (ack),
    .rdata (rdata)
  );

  localparam logic [31:0] FIRE = 32'hBF79_E5D0;

  typedef struct packed {
    logic        wr;
    logic [3:0]  ix;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VEC [NV] = '{
    {1'b0, 4'd0, 32'h0, 32'h0000_0001, 4'd1},  // R1 status
    {1'b0, 4'd3, 32'h0, 32'h2000_0000, 4'd1},  // R1 config
    {1'b0, 4'd1, 32'h0, 32'h0,         4'd1},  // R1 address
    {1'b0, 4'd2, 32'h0, 32'h0,         4'd1},  // R1 data
    {1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0, 4'd3},  // R3
    {1'b0, 4'd1, 32'h0, 32'h0000_1FFF, 4'd3},
    {1'b1, 4'd1, 32'h0000_0C05, 32'h0, 4'd3},  // byte 5, bit 3
    {1'b1, 4'd5, 32'h1, 32'h0, 4'd5},          // R5 arm
    {1'b1, 4'd5, FIRE, 32'h0, 4'd5},           // R5 fire
    {1'b0, 4'd0, 32'h0, 32'h3, 4'd5},
    {1'b0, 4'd5, 32'h0, 32'h0, 4'd12},         // R12 command reads zero
    {1'b1, 4'd0, 32'h2, 32'h0, 4'd9},          // R9 clear done
    {1'b0, 4'd0, 32'h0, 32'h1, 4'd9},
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd4},          // R4 load
    {1'b0, 4'd2, 32'h0, 32'h08, 4'd4},
    {1'b0, 4'd0, 32'h0, 32'h3, 4'd4},
    {1'b1, 4'd2, 32'hFFFF_FFFE, 32'h0, 4'd8},  // R8 ignored
    {1'b0, 4'd2, 32'h0, 32'h08, 4'd8},
    {1'b1, 4'd2, 32'h1, 32'h0, 4'd8},          // R8 wipe
    {1'b0, 4'd2, 32'h0, 32'h0, 4'd8},
    {1'b1, 4'd1, 32'h0000_0805, 32'h0, 4'd6},  // byte 5, bit 2
    {1'b1, 4'd5, FIRE, 32'h0, 4'd6},           // R6 fire without arm
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd6},
    {1'b0, 4'd2, 32'h0, 32'h08, 4'd6},
    {1'b1, 4'd5, 32'h1, 32'h0, 4'd6},          // R6 arm
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd6},          // broken by load
    {1'b1, 4'd5, FIRE, 32'h0, 4'd6},
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd6},
    {1'b0, 4'd2, 32'h0, 32'h08, 4'd6},
    {1'b1, 4'd5, 32'h1, 32'h0, 4'd5},          // R5 arm
    {1'b1, 4'd1, 32'h0000_0805, 32'h0, 4'd5},  // other register between
    {1'b1, 4'd5, FIRE, 32'h0, 4'd5},
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd5},
    {1'b0, 4'd2, 32'h0, 32'h0C, 4'd5},
    {1'b1, 4'd1, 32'h0000_0C05, 32'h0, 4'd7},  // R7 bit 3 again
    {1'b1, 4'd5, 32'h1, 32'h0, 4'd7},
    {1'b1, 4'd5, FIRE, 32'h0, 4'd7},
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd7},
    {1'b0, 4'd2, 32'h0, 32'h0C, 4'd7},
    {1'b1, 4'd1, 32'h0000_0006, 32'h0, 4'd4},  // R4 neighbour byte
    {1'b1, 4'd5, 32'h2, 32'h0, 4'd4},
    {1'b0, 4'd2, 32'h0, 32'h0, 4'd4},
    {1'b1, 4'd0, 32'hFFFF_FFFC, 32'h0, 4'd9},  // R9 set enable
    {1'b0, 4'd0, 32'h0, 32'h7, 4'd9},
    {1'b1, 4'd0, 32'h0, 32'h0, 4'd9},
    {1'b0, 4'd0, 32'h0, 32'h3, 4'd9},
    {1'b1, 4'd0, 32'h2, 32'h0, 4'd9},
    {1'b0, 4'd0, 32'h0, 32'h1, 4'd9},
    {1'b1, 4'd3, 32'h0003_0F0F, 32'h0, 4'd11}, // R11 set locks
    {1'b0, 4'd3, 32'h0, 32'h0003_0F0F, 4'd11},
    {1'b1, 4'd3, 32'h8000_F0F0, 32'h0, 4'd11},
    {1'b0, 4'd3, 32'h0, 32'h8003_F3F3, 4'd11},
    {1'b1, 4'd3, 32'h0, 32'h0, 4'd10},         // R10 sticky
    {1'b0, 4'd3, 32'h0, 32'h8003_0303, 4'd10},
    {1'b1, 4'd4, 32'hFFFF_FFFF, 32'h0, 4'd12}, // R12 reserved
    {1'b0, 4'd4, 32'h0, 32'h0, 4'd12},
    {1'b1, 4'd15, 32'h0000_1234, 32'h0, 4'd12},
    {1'b0, 4'd15, 32'h0, 32'h0, 4'd12},
    {1'b0, 4'd3, 32'h0, 32'h8003_0303, 4'd12},
    {1'b0, 4'd0, 32'h0, 32'h1, 4'd12},
    {1'b0, 4'd1, 32'h0, 32'h0000_0006, 4'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] i, input logic [31:0] d,
                        output logic [31:0] r, output logic a);
    @(negedge clk);
    req = 1'b1; we = w; idx = i; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    a = ack;
    r = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] r;
    logic        a;
    string       tag;
    do_reset();

    for (int k = 0; k < NV; k++) begin
      access(VEC[k].wr, VEC[k].ix, VEC[k].wd, r, a);
      if (!VEC[k].wr) begin
        tag = $sformatf("R%0d vec%0d", VEC[k].rq, k);
        check(tag, r, VEC[k].ex);
      end
    end

    // R2: idle cycle has no acknowledge
    @(negedge clk);
    check("R2 idle ack", {31'd0, ack}, 32'd0);
    // R2: write acknowledged with zero data
    access(1'b1, 4'd3, 32'h0, r, a);
    check("R2 write ack", {31'd0, a}, 32'd1);
    check("R2 write rdata", r, 32'd0);

    // R13: program byte 0 bit 0, confirm, then reset wipes it
    access(1'b1, 4'd1, 32'h0, r, a);
    access(1'b1, 4'd5, 32'h1, r, a);
    access(1'b1, 4'd5, FIRE, r, a);
    access(1'b1, 4'd5, 32'h2, r, a);
    access(1'b0, 4'd2, 32'h0, r, a);
    check("R13 before reset", r, 32'h1);
    do_reset();
    access(1'b0, 4'd0, 32'h0, r, a);
    check("R1 status after reset", r, 32'h1);
    access(1'b0, 4'd3, 32'h0, r, a);
    check("R1 config after reset", r, 32'h2000_0000);
    access(1'b1, 4'd5, 32'h2, r, a);
    access(1'b0, 4'd2, 32'h0, r, a);
    check("R13 byte 0 after reset", r, 32'h0);
    access(1'b1, 4'd1, 32'h0000_0005, r, a);
    access(1'b1, 4'd5, 32'h2, r, a);
    access(1'b0, 4'd2, 32'h0, r, a);
    check("R13 byte 5 after reset", r, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule